// File: doc/BRIEF.md
# Serial-Loaded Wiper Code Register

This block is the digital control core of a 128-step digitally controlled resistor. A host writes a wiper code over a three-wire serial link: a serial clock, an active-low select and a data line. Each rising serial clock edge moves one data bit into a 7-bit shift register while the select is low. When the select returns high, the last seven bits shifted are copied into a 7-bit wiper latch. The latch value is the `wiper_code` output, which the analog tap decoder uses. Code 0 selects the bottom (B) end and each increment moves the wiper one tap up.

The far end of the shift register drives an open-drain serial output, so several devices can be chained on one select. All three serial inputs are oversampled by a fast system clock through a synchronizer, and edges are detected in that domain. A midscale input, active low, forces the latch to 40H at once and clears the shift register. A power-down input, active low, raises the terminal-control flags and releases the serial output. It does not disturb the latch or the serial interface.

Top module: `wiper_ctl`

## Requirements
- R1: While the select is low, every rising serial clock edge shifts the data bit into bit 0 of the shift register. The bit shifted last becomes bit 0 of the loaded code and the bit shifted seven edges earlier becomes bit 6 (MSB first).
- R2: On a rising select edge the shift register is copied into the wiper latch. Bits shifted before the last seven are lost. A frame of fewer than seven bits combines the new bits with the earlier shift register contents.
- R3: The serial output enables its pull-down only when the bit shifted in seven edges earlier (shift register bit 6) is 0 and power-down is inactive. Two chained devices loaded with 14 edges under one select end with the first seven bits in the downstream device and the last seven in the upstream device.
- R4: Serial clock edges while the select is high change neither the shift register nor the latch.
- R5: While the midscale input is low, `wiper_code` is 40H without waiting for a system clock edge, and the shift register is cleared. After release, 40H stays until the next load.
- R6: A rising select edge that arrives while the midscale input is low leaves the latch at 40H.
- R7: While power-down is low, `term_a_open` and `wiper_to_b` are 1 and `sdo_pull_en` is 0. Otherwise both flags are 0.
- R8: The latch keeps its value through power-down. Frames sent during power-down still load the latch, and the loaded code is present when power-down ends.
- R9: The synchronous system reset `rst_n` sets the latch to 40H, clears the shift register and ignores serial activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Synchronous system reset, active low |
| ser_clk | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_sel_n | input | 1 | Serial select, active low; a rising edge loads the latch |
| ser_din | input | 1 | Serial data in |
| mid_n | input | 1 | Asynchronous midscale force, active low |
| pwr_dn_n | input | 1 | Power-down, active low |
| wiper_code | output | 7 | Wiper latch contents |
| sdo_pull_en | output | 1 | Pull-down enable for the open-drain serial output |
| term_a_open | output | 1 | Request to open the A terminal |
| wiper_to_b | output | 1 | Request to tie the wiper to the B terminal |

## Verification
Frames of exactly seven bits with all-ones, all-zeros and alternating data confirm the bit order and the plain load. Longer frames of 9 to 16 bits show that only the final seven bits survive. Short frames of one and three bits show that the new bits merge with the earlier contents instead of zero-filling. A two-device chain loaded with 14 bits separates a correct seven-edge output delay from an off-by-one, and deselected clocks followed by a one-bit frame expose any shift that happens outside a frame. Directed sequences cover the midscale force during a load and a power-down that takes a new code.

// File: rtl/wiper_pkg.sv
// Shared constants and helpers for the wiper code register.
package wiper_pkg;

    // Midscale code for a given code width: only the MSB set.
    function automatic logic [15:0] midscale(input int w);
        return 16'(1) << (w - 1);
    endfunction

    // Reset value of the synchronized serial inputs {clk, sel_n, din}.
    localparam logic [2:0] SER_IDLE = 3'b010;

endpackage

// File: rtl/wiper_sync.sv
// Multi-stage synchronizer for a vector of slow asynchronous inputs.
// Assumes every bit is allowed the same latency, so that bits sampled
// together stay aligned after the last stage.
module wiper_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: one sampling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_chain
            // Purpose: shift the samples through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/wiper_frontend.sv
// Edge detector for the synchronized serial clock and select.
// Produces a one-cycle shift strobe on a selected rising serial clock
// and a one-cycle load strobe on a rising select.
// Assumes the inputs are already synchronized to clk.
module wiper_frontend (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic sel_n_s,
    output logic shift_en,
    output logic load_en
);

    logic sclk_d;
    logic sel_n_d;

    // Purpose: hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b1;
            sel_n_d <= 1'b1;
        end else begin
            sclk_d  <= sclk_s;
            sel_n_d <= sel_n_s;
        end
    end

    // Purpose: form the strobes from level changes.
    always_comb begin
        shift_en = sclk_s && !sclk_d && !sel_n_s;
        load_en  = sel_n_s && !sel_n_d;
    end

endmodule

// File: rtl/wiper_shreg.sv
// Serial-in shift register. The MSB is the serial output tap.
// Cleared at once by the midscale input and synchronously by rst_n.
module wiper_shreg #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mid_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [CODE_W-1:0] q
);

    // Purpose: clear on midscale/reset, else shift in one bit per strobe.
    always_ff @(posedge clk or negedge mid_n) begin
        if (!mid_n)         q <= '0;
        else if (!rst_n)    q <= '0;
        else if (shift_en)  q <= {q[CODE_W-2:0], din};
    end

endmodule

// File: rtl/wiper_latch.sv
// Wiper code latch. It loads the shift register on a load strobe and is
// forced to midscale at once while mid_n is low, so midscale overrides
// a load in the same cycle.
module wiper_latch #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mid_n,
    input  logic              load_en,
    input  logic [CODE_W-1:0] d,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] MID = CODE_W'(wiper_pkg::midscale(CODE_W));

    // Purpose: midscale force, reset, or load from the shift register.
    always_ff @(posedge clk or negedge mid_n) begin
        if (!mid_n)        code <= MID;
        else if (!rst_n)   code <= MID;
        else if (load_en)  code <= d;
    end

endmodule

// File: rtl/wiper_ctl.sv
// Top of the serial-loaded wiper code register.
// The serial inputs are oversampled by clk, which must be several times
// faster than ser_clk. The power-down outputs are combinational from
// pwr_dn_n. The open-drain output is modelled as a pull-down enable.
module wiper_ctl #(
    parameter int CODE_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_sel_n,
    input  logic              ser_din,
    input  logic              mid_n,
    input  logic              pwr_dn_n,
    output logic [CODE_W-1:0] wiper_code,
    output logic              sdo_pull_en,
    output logic              term_a_open,
    output logic              wiper_to_b
);

    logic [2:0]        ser_s;
    logic              sclk_s;
    logic              sel_n_s;
    logic              din_s;
    logic              shift_en;
    logic              load_en;
    logic [CODE_W-1:0] shift_q;

    wiper_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (wiper_pkg::SER_IDLE)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_sel_n, ser_din}),
        .q     (ser_s)
    );

    assign {sclk_s, sel_n_s, din_s} = ser_s;

    wiper_frontend i_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .sel_n_s  (sel_n_s),
        .shift_en (shift_en),
        .load_en  (load_en)
    );

    wiper_shreg #(.CODE_W(CODE_W)) i_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mid_n    (mid_n),
        .shift_en (shift_en),
        .din      (din_s),
        .q        (shift_q)
    );

    wiper_latch #(.CODE_W(CODE_W)) i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .mid_n   (mid_n),
        .load_en (load_en),
        .d       (shift_q),
        .code    (wiper_code)
    );

    // Purpose: terminal flags and the open-drain pull-down enable.
    always_comb begin
        term_a_open = !pwr_dn_n;
        wiper_to_b  = !pwr_dn_n;
        sdo_pull_en = pwr_dn_n && !shift_q[CODE_W-1];
    end

endmodule

// File: rtl/wiper_ctl_chk.sv
// Assertion checker for wiper_ctl, attached by bind below.
module wiper_ctl_chk #(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mid_n,
    input logic              pwr_dn_n,
    input logic              sel_n_s,
    input logic              load_en,
    input logic [CODE_W-1:0] shift_q,
    input logic [CODE_W-1:0] wiper_code,
    input logic              sdo_pull_en,
    input logic              term_a_open,
    input logic              wiper_to_b
);

    localparam logic [CODE_W-1:0] MID = CODE_W'(wiper_pkg::midscale(CODE_W));

    // R4: no shift while the synchronized select is high
    a_r4_no_shift_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_n && sel_n_s) |=> (!mid_n || $stable(shift_q)));

    // R2: the latch moves only on a load strobe
    a_r2_latch_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_n && !load_en) |=> (!mid_n || $stable(wiper_code)));

    // R5: midscale held while the force is active
    a_r5_midscale_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !mid_n |-> (wiper_code == MID && shift_q == '0));

    // R7: power-down flags and released serial output
    a_r7_shutdown_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |-> (term_a_open && wiper_to_b && !sdo_pull_en));

    // R7: flags clear outside power-down
    a_r7_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_n |-> (!term_a_open && !wiper_to_b));

    // R3: pull-down never enabled in power-down, and tracks the tap
    a_r3_pull_tap: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_pull_en |-> (pwr_dn_n && !shift_q[CODE_W-1]));

endmodule

bind wiper_ctl wiper_ctl_chk #(.CODE_W(CODE_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mid_n       (mid_n),
    .pwr_dn_n    (pwr_dn_n),
    .sel_n_s     (sel_n_s),
    .load_en     (load_en),
    .shift_q     (shift_q),
    .wiper_code  (wiper_code),
    .sdo_pull_en (sdo_pull_en),
    .term_a_open (term_a_open),
    .wiper_to_b  (wiper_to_b)
);

// File: tb/test_wiper_ctl.sv
module test_wiper_ctl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sel_n = 1'b1;
    logic sdi = 1'b0;
    logic mid_n = 1'b1;
    logic pwr_n = 1'b1;

    logic [6:0] a_code, b_code;
    logic       a_pull, b_pull, a_aopen, b_aopen, a_wb, b_wb;
    logic       sdi_b;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] m_sr = '0;

    always #5 clk = ~clk;

    // Open-drain chain node with pull-up.
    assign sdi_b = a_pull ? 1'b0 : 1'b1;

    wiper_ctl i_wiper_ctl (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_sel_n(sel_n),
        .ser_din(sdi), .mid_n(mid_n), .pwr_dn_n(pwr_n),
        .wiper_code(a_code), .sdo_pull_en(a_pull),
        .term_a_open(a_aopen), .wiper_to_b(a_wb)
    );

    wiper_ctl i_wiper_ctl_dn (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_sel_n(sel_n),
        .ser_din(sdi_b), .mid_n(mid_n), .pwr_dn_n(pwr_n),
        .wiper_code(b_code), .sdo_pull_en(b_pull),
        .term_a_open(b_aopen), .wiper_to_b(b_wb)
    );

    // {bit count, pattern sent MSB first}
    localparam logic [20:0] VEC [10] = '{
        {5'd7,  16'h007F}, {5'd7,  16'h0000}, {5'd7,  16'h002A},
        {5'd10, 16'h03A5}, {5'd3,  16'h0005}, {5'd12, 16'h0ABC},
        {5'd1,  16'h0001}, {5'd16, 16'hF0F0}, {5'd7,  16'h0001},
        {5'd9,  16'h01FE}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] pat, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0;
            sdi  = pat[i];
            wait_clk(4);
            sclk = 1'b1;
            if (!sel_n) m_sr = {m_sr[5:0], pat[i]};
            wait_clk(4);
        end
        sclk = 1'b0;
        wait_clk(2);
    endtask

    task automatic frame(input logic [15:0] pat, input int n);
        sel_n = 1'b0;
        wait_clk(4);
        shift_bits(pat, n);
        sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R9: reset state
        chk(a_code == 7'h40, "R9 reset code", a_code, 7'h40);
        chk(a_pull == 1'b1, "R9 cleared register pulls low", a_pull, 1);
        chk(!a_aopen && !a_wb, "R7 flags idle", {a_aopen, a_wb}, 0);

        // R1 R2: table of frames
        foreach (VEC[k]) begin
            frame(VEC[k][15:0], int'(VEC[k][20:16]));
            chk(a_code == m_sr, "R1/R2 frame load", a_code, m_sr);
            chk(a_pull == !m_sr[6], "R3 pull tap", a_pull, !m_sr[6]);
        end
        chk(a_code == 7'h7E, "R2 extra bits dropped", a_code, 7'h7E);

        // R5: asynchronous midscale force
        #2 mid_n = 1'b0;
        #1 chk(a_code == 7'h40, "R5 immediate midscale", a_code, 7'h40);
        wait_clk(3);
        mid_n = 1'b1;
        m_sr = '0;
        wait_clk(3);
        chk(a_code == 7'h40, "R5 holds after release", a_code, 7'h40);

        // R6: midscale wins over a load
        sel_n = 1'b0;
        wait_clk(4);
        shift_bits(16'h0011, 7);
        mid_n = 1'b0;
        m_sr = '0;
        wait_clk(2);
        sel_n = 1'b1;
        wait_clk(8);
        chk(a_code == 7'h40, "R6 load during midscale", a_code, 7'h40);
        mid_n = 1'b1;
        wait_clk(4);
        chk(a_code == 7'h40, "R6 after release", a_code, 7'h40);
        frame(16'h0005, 3);
        chk(a_code == 7'h05, "R5 register cleared", a_code, 7'h05);

        // R4: clocks while deselected are ignored
        shift_bits(16'h001F, 5);
        frame(16'h0000, 1);
        chk(a_code == 7'h0A, "R4 deselected clocks", a_code, 7'h0A);

        // R7 R8: shutdown sequence
        pwr_n = 1'b0;
        wait_clk(2);
        chk(a_aopen && a_wb, "R7 flags set", {a_aopen, a_wb}, 3);
        chk(a_pull == 1'b0, "R7 serial output released", a_pull, 0);
        chk(a_code == 7'h0A, "R8 code kept", a_code, 7'h0A);
        frame(16'h0033, 7);
        chk(a_code == 7'h33, "R8 load in shutdown", a_code, 7'h33);
        chk(a_pull == 1'b0, "R7 still released", a_pull, 0);
        pwr_n = 1'b1;
        wait_clk(2);
        chk(!a_aopen && !a_wb, "R7 flags clear", {a_aopen, a_wb}, 0);
        chk(a_code == 7'h33, "R8 code after exit", a_code, 7'h33);
        chk(a_pull == 1'b1, "R3 pull after exit", a_pull, 1);

        // R3: two-device chain, 14 bits
        frame(16'h2B5D, 14);
        chk(b_code == 7'h56, "R3 downstream code", b_code, 7'h56);
        chk(a_code == 7'h5D, "R3 upstream code", a_code, 7'h5D);
        chk(a_pull == 1'b0, "R3 tap after chain", a_pull, 0);

        // R9: synchronous reset returns to midscale
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(2);
        chk(a_code == 7'h40, "R9 reset after use", a_code, 7'h40);
        chk(b_code == 7'h40, "R9 reset downstream", b_code, 7'h40);

        finish_run();
    end

endmodule